// File: doc/BRIEF.md
# Carrier board management controller

This block is the control core of a small management controller on a carrier board. After reset it brings up module power and then the adjustable supply rail, each after a programmable delay. It holds the module in reset until both supplies are up and a minimum settling time has passed. It also turns a pair of mode DIP switches into a three-bit supply voltage code and a JTAG target select, and it picks SD or flash boot from a card-detect input. A UART is passed straight through between the USB bridge and the module.

Eight user LEDs show either local board status or bits received over a remote-GPIO link. The link bits are used only when the link reports that its far end has been detected. The serial link itself sits outside this block: its received bits and its detect flag arrive as plain synchronous inputs.

Switch, button, card-detect and spare inputs each pass through two flip-flops. The reset button is also debounced before it can reach the module reset.

Top module: `cbmc_top`

## Requirements
- R1: While it is allowed to update, the voltage code follows the synchronized switches (1 = switch on). Both off or both on gives V18_CODE (default 3'b000). M1 off with M2 on gives V25_CODE (3'b001). M1 on with M2 off gives V33_CODE (3'b010). Every synchronized input lags its pin by two clock edges.
- R2: The voltage code resets to V18_CODE. It updates only on edges where `rail_en` is low, and it holds its value while `rail_en` is high.
- R3: `mod_pwr_en` rises on the PWR_DLY1-th clock edge after reset release. `rail_en` rises PWR_DLY2 edges after that. Neither is high during reset, and both stay high until the next reset.
- R4: `mod_rst_n` stays low until RST_HOLD edges after `rail_en` rises. After that it is low exactly while the debounced button is pressed.
- R5: The debounced button (1 = pressed) takes a new value only after the synchronized button has differed from it on DEB_CYC consecutive edges. A shorter pulse has no effect on `mod_rst_n`.
- R6: `jtag_mod` is high exactly when both synchronized switches are on.
- R7: `boot_sd` equals the synchronized card-detect input (1 = card present = SD boot, 0 = flash boot).
- R8: `mod_rx_o` equals `usb_rx_i`, and `usb_tx_o` equals `mod_tx_i`, combinationally.
- R9: While `rio_det` is high, `led[i]` equals `rio_bits[i]` for i = 0 to 7.
- R10: While `rio_det` is low, the LEDs show local status:
  - `led[0]` = `mod_rst_n`
  - `led[1]` = both switches off
  - `led[2]` = `usb_rx_i`
  - `led[3]` = `mod_tx_i`
  - `led[4]` = synchronized card detect
  - `led[5]` = M1 on with M2 off
  - `led[6]` = synchronized `spare_a`
  - `led[7]` = synchronized `spare_b`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_m1 | input | 1 | Mode switch 1, 1 = on |
| sw_m2 | input | 1 | Mode switch 2, 1 = on |
| btn_rst | input | 1 | User reset button, 1 = pressed |
| card_det | input | 1 | SD card present |
| spare_a | input | 1 | Spare status pin A |
| spare_b | input | 1 | Spare status pin B |
| usb_rx_i | input | 1 | Receive line from USB bridge |
| mod_tx_i | input | 1 | Module UART transmit pin |
| rio_det | input | 1 | Remote-GPIO far end detected |
| rio_bits | input | 8 | Remote-GPIO received LED bits |
| mod_pwr_en | output | 1 | Module power enable |
| rail_en | output | 1 | Adjustable rail enable |
| vsel | output | 3 | Adjustable rail voltage code |
| jtag_mod | output | 1 | JTAG targets module controller |
| mod_rst_n | output | 1 | Module reset, active low |
| boot_sd | output | 1 | 1 = SD boot, 0 = flash boot |
| mod_rx_o | output | 1 | Module UART receive pin |
| usb_tx_o | output | 1 | Transmit line to USB bridge |
| led | output | 8 | User LEDs |

## Verification
The hardest state to reach is a switch change after the rail is live. There the JTAG select must follow the switches at once while the voltage code stays frozen. The stimulus moves the switches through several codes during the power-up window, then selects the both-on code once the rail is enabled. Later a second reset unfreezes the code and shows that it picks up the new setting. The button is first held for one cycle less than the debounce length and then for well past it, so both sides of the threshold are seen at `mod_rst_n`.

// File: rtl/cbmc_pkg.sv
package cbmc_pkg;
  typedef logic [2:0] vcode_t;

  function automatic vcode_t vsel_decode(input logic m1, input logic m2,
                                         input vcode_t c18, input vcode_t c25,
                                         input vcode_t c33);
    vcode_t r;
    unique case ({m1, m2})
      2'b01:   r = c25;
      2'b10:   r = c33;
      default: r = c18;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] led_local(input logic rst_n_out, input logic m1,
                                           input logic m2, input logic rx,
                                           input logic tx, input logic card,
                                           input logic spa, input logic spb);
    return {spb, spa, m1 & ~m2, card, tx, rx, ~m1 & ~m2, rst_n_out};
  endfunction
endpackage

// File: rtl/cbmc_sync.sv
module cbmc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/cbmc_debounce.sv
module cbmc_debounce #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;
  logic          state;
  logic          differs;

  assign differs = (d != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      state <= 1'b0;
    end else if (differs) begin
      if (cnt == LAST) begin
        state <= d;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  assign q = state;

  AST_DB_AGREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> (cnt == '0)); // R5
  AST_DB_CHANGE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (differs && cnt != LAST) |=> (state == $past(state))); // R5
endmodule

// File: rtl/cbmc_power_seq.sv
module cbmc_power_seq #(
  parameter int D1   = 1000,
  parameter int D2   = 1000,
  parameter int HOLD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic pwr_on,
  output logic rail_on,
  output logic hold_done
);
  localparam int TOT = D1 + D2 + HOLD;
  localparam int W   = $clog2(TOT + 1);
  localparam logic [W-1:0] LIM1 = W'(D1);
  localparam logic [W-1:0] LIM2 = W'(D1 + D2);
  localparam logic [W-1:0] LIM3 = W'(TOT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != LIM3) cnt <= cnt + 1'b1;
  end

  assign pwr_on    = (cnt >= LIM1);
  assign rail_on   = (cnt >= LIM2);
  assign hold_done = (cnt == LIM3);

  AST_RAIL_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    rail_on |-> pwr_on); // R3
  AST_PWR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on |=> pwr_on); // R3
  AST_RAIL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    rail_on |=> rail_on); // R3
endmodule

// File: rtl/cbmc_top.sv
module cbmc_top
  import cbmc_pkg::*;
#(
  parameter int     PWR_DLY1 = 5000,
  parameter int     PWR_DLY2 = 5000,
  parameter int     RST_HOLD = 2000,
  parameter int     DEB_CYC  = 1000,
  parameter vcode_t V18_CODE = 3'b000,
  parameter vcode_t V25_CODE = 3'b001,
  parameter vcode_t V33_CODE = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_m1,
  input  logic       sw_m2,
  input  logic       btn_rst,
  input  logic       card_det,
  input  logic       spare_a,
  input  logic       spare_b,
  input  logic       usb_rx_i,
  input  logic       mod_tx_i,
  input  logic       rio_det,
  input  logic [7:0] rio_bits,
  output logic       mod_pwr_en,
  output logic       rail_en,
  output logic [2:0] vsel,
  output logic       jtag_mod,
  output logic       mod_rst_n,
  output logic       boot_sd,
  output logic       mod_rx_o,
  output logic       usb_tx_o,
  output logic [7:0] led
);
  localparam int NSYNC = 6;

  logic [NSYNC-1:0] raw_in, syn;
  logic m1_s, m2_s, btn_s, card_s, spa_s, spb_s;
  logic btn_db;
  logic hold_done;
  vcode_t vsel_q;
  vcode_t vsel_next;
  logic [7:0] led_loc;

  assign raw_in = {spare_b, spare_a, card_det, btn_rst, sw_m2, sw_m1};

  cbmc_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign {spb_s, spa_s, card_s, btn_s, m2_s, m1_s} = syn;

  cbmc_debounce #(.CYC(DEB_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .d(btn_s), .q(btn_db)
  );

  cbmc_power_seq #(.D1(PWR_DLY1), .D2(PWR_DLY2), .HOLD(RST_HOLD)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_on(mod_pwr_en), .rail_on(rail_en),
    .hold_done(hold_done)
  );

  assign vsel_next = vsel_decode(m1_s, m2_s, V18_CODE, V25_CODE, V33_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsel_q <= V18_CODE;
    else if (!rail_en) vsel_q <= vsel_next;
  end

  assign vsel      = vsel_q;
  assign jtag_mod  = m1_s & m2_s;
  assign mod_rst_n = hold_done & ~btn_db;
  assign boot_sd   = card_s;
  assign mod_rx_o  = usb_rx_i;
  assign usb_tx_o  = mod_tx_i;

  assign led_loc = led_local(mod_rst_n, m1_s, m2_s, usb_rx_i, mod_tx_i,
                             card_s, spa_s, spb_s);
  assign led     = rio_det ? rio_bits : led_loc;

  AST_VSEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rail_en |=> $stable(vsel)); // R2
  AST_RST_UNTIL_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_en |-> !mod_rst_n); // R4
  AST_BTN_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    btn_db |-> !mod_rst_n); // R4
  AST_JTAG_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    jtag_mod |-> (led_loc[1] == 1'b0 && led_loc[5] == 1'b0)); // R6
endmodule

// File: tb/cbmc_top_tb.sv
`timescale 1ns/100ps
module cbmc_top_tb;
  localparam int D1 = 20, D2 = 15, HOLD = 10, DEB = 6;

  logic clk = 0, rst_n = 0;
  logic sw_m1 = 0, sw_m2 = 1, btn_rst = 0, card_det = 0;
  logic spare_a = 0, spare_b = 0, usb_rx_i = 1, mod_tx_i = 1;
  logic rio_det = 0;
  logic [7:0] rio_bits = 8'h00;
  logic mod_pwr_en, rail_en, jtag_mod, mod_rst_n, boot_sd, mod_rx_o, usb_tx_o;
  logic [2:0] vsel;
  logic [7:0] led;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cbmc_top #(.PWR_DLY1(D1), .PWR_DLY2(D2), .RST_HOLD(HOLD), .DEB_CYC(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_m1(sw_m1), .sw_m2(sw_m2), .btn_rst(btn_rst),
    .card_det(card_det), .spare_a(spare_a), .spare_b(spare_b),
    .usb_rx_i(usb_rx_i), .mod_tx_i(mod_tx_i), .rio_det(rio_det),
    .rio_bits(rio_bits), .mod_pwr_en(mod_pwr_en), .rail_en(rail_en),
    .vsel(vsel), .jtag_mod(jtag_mod), .mod_rst_n(mod_rst_n),
    .boot_sd(boot_sd), .mod_rx_o(mod_rx_o), .usb_tx_o(usb_tx_o), .led(led)
  );

  // reference model state
  bit p1[6], p2[6];      // two-stage pipes: m1 m2 btn card spa spb
  int since_rel;         // edges since reset release
  int diff_run;          // consecutive edges button pipe disagrees with debounced
  bit pressed;
  int code;

  function automatic int code_of(bit m1, bit m2);
    if (m1 && !m2) return 2;
    if (!m1 && m2) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    foreach (p1[i]) begin p1[i] = 0; p2[i] = 0; end
    since_rel = 0; diff_run = 0; pressed = 0; code = 0;
  endtask

  task automatic model_edge();
    bit now[6];
    now = '{sw_m1, sw_m2, btn_rst, card_det, spare_a, spare_b};
    if (since_rel < D1 + D2) code = code_of(p2[0], p2[1]);
    if (p2[2] != pressed) begin
      diff_run++;
      if (diff_run == DEB) begin pressed = p2[2]; diff_run = 0; end
    end else diff_run = 0;
    if (since_rel < D1 + D2 + HOLD) since_rel++;
    p2 = p1;
    p1 = now;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_pwr, e_rail, e_rstn;
    logic [7:0] e_led;
    e_pwr  = since_rel >= D1;
    e_rail = since_rel >= D1 + D2;
    e_rstn = (since_rel == D1 + D2 + HOLD) && !pressed;
    chk("R3 mod_pwr_en", mod_pwr_en, e_pwr);
    chk("R3 rail_en", rail_en, e_rail);
    chk("R1 R2 vsel", vsel, code);
    chk("R4 R5 mod_rst_n", mod_rst_n, e_rstn);
    chk("R6 jtag_mod", jtag_mod, p2[0] & p2[1]);
    chk("R7 boot_sd", boot_sd, p2[3]);
    chk("R8 mod_rx_o", mod_rx_o, usb_rx_i);
    chk("R8 usb_tx_o", usb_tx_o, mod_tx_i);
    if (rio_det) chk("R9 led", led, rio_bits);
    else begin
      e_led = {p2[5], p2[4], p2[0] & !p2[1], p2[3], mod_tx_i, usb_rx_i,
               !p2[0] & !p2[1], e_rstn};
      chk("R10 led", led, e_led);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      if (!rst_n) model_reset(); else model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    step(3);
    chk("R3 reset mod_pwr_en", mod_pwr_en, 0);
    chk("R4 reset mod_rst_n", mod_rst_n, 0);
    chk("R2 reset vsel", vsel, 0);
    rst_n = 1;
    step(5);
    sw_m1 = 1; sw_m2 = 0;
    step(10);
    chk("R1 vsel 3v3 before rail", vsel, 2);
    sw_m1 = 0; sw_m2 = 0; card_det = 1;
    step(25);
    chk("R3 rail_en up", rail_en, 1);
    sw_m1 = 1; sw_m2 = 1;
    step(5);
    chk("R6 jtag both on", jtag_mod, 1);
    chk("R2 vsel frozen", vsel, 0);
    usb_rx_i = 0;
    step(2);
    mod_tx_i = 0; spare_a = 1;
    step(5);
    chk("R4 released", mod_rst_n, 1);
    btn_rst = 1; step(DEB - 1); btn_rst = 0;
    step(10);
    chk("R5 short press ignored", mod_rst_n, 1);
    btn_rst = 1; step(12);
    chk("R5 long press resets", mod_rst_n, 0);
    btn_rst = 0; step(12);
    rio_det = 1; rio_bits = 8'hA5; step(3);
    rio_bits = 8'h3C; step(3);
    chk("R9 remote bits", led, 8'h3C);
    rio_det = 0; sw_m1 = 1; sw_m2 = 0; step(5);
    card_det = 0; spare_b = 1; step(5);
    rst_n = 0; step(2);
    rst_n = 1; step(50);
    chk("R1 vsel resampled", vsel, 2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule